// File: doc/BRIEF.md
# Non-Restoring Division Step Unit

This block performs one iteration of a non-restoring binary division per command. It keeps a partial remainder register, a held copy of the divisor and three state bits: Q, M and T. Q and M decide whether the next iteration adds or subtracts the divisor. T carries the quotient bit that the following iteration shifts into the remainder. Two set-up commands prepare the state for an unsigned or a signed division, and the step command advances the division by one bit.

A surrounding sequencer issues one set-up command and then thirty-two steps. Before each step it rotates the low dividend word left through T, which it writes back through a fourth command that loads T. A final rotate then leaves the quotient in the low word. For signed division the sequencer sign-extends the dividend into the word given to the set-up command. When that dividend is negative, it also uses one's-complement pre- and post-correction. Every command takes one clock and can be issued back to back.

Top module: `divstep_unit`

## Requirements
- R1: While reset is low at a clock edge, the remainder, Q, M, T and done outputs become 0, and they read 0 on the first cycle after reset is released.
- R2: Command code 0 (unsigned set-up) loads the remainder from opnd_a and the divisor from opnd_b, and clears Q, M and T.
- R3: Command code 1 (signed set-up) loads the remainder and divisor the same way. Q takes bit 31 of opnd_a, M takes bit 31 of opnd_b, and T becomes Q XOR M.
- R4: Command code 2 (step) takes the old remainder's bit 31 as the interim Q. It then shifts the remainder left by one with the current T in bit 0. M is left unchanged.
- R5: In a step where the old Q equals M, the held divisor is subtracted from the shifted remainder, and the carry is 1 exactly when the divisor exceeds the shifted value (a borrow).
- R6: In a step where the old Q differs from M, the divisor is added, and the carry is the bit lost off the top of the 32-bit sum.
- R7: After a step, Q is the interim Q XOR M XOR the carry, and T is 1 exactly when that new Q equals M.
- R8: Command code 3 loads T from t_in and leaves the remainder, Q and M unchanged.
- R9: done is high for exactly the cycle after each accepted command. With cmd_valid low, all outputs hold their values.
- R10: An unsigned set-up, followed by 32 rotate-and-step iterations and a final rotate, leaves the exact unsigned quotient in the low word.
- R11: The signed sequence, with the dividend sign-extended and one's-complement corrected, yields the quotient truncated toward zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 2 | Command code: 0 unsigned set-up, 1 signed set-up, 2 step, 3 load T |
| opnd_a | input | W | Upper dividend word for the set-up commands |
| opnd_b | input | W | Divisor for the set-up commands |
| t_in | input | 1 | New T value for command 3 |
| rem_out | output | W | Partial remainder register |
| q_out | output | 1 | Q state bit |
| m_out | output | 1 | M state bit (divisor sign) |
| t_out | output | 1 | T state bit (next quotient bit) |
| done | output | 1 | Pulses the cycle after a command is accepted |

## Verification
Every result of this block is due exactly one rising edge after the command is accepted. This covers the remainder, Q, M, T and done. The bench drives each command on a falling edge and reads the outputs at the next falling edge, after the register update and well before the following edge. Back-to-back commands therefore give one fresh result per cycle. In the full division sequences the bench reads T at that same point before it computes the next rotate. Hold behaviour is checked one idle cycle after a command, when done must already have fallen.

// File: rtl/divstep_pkg.sv
// Package: shared command codes and state-bit bundle for the division step unit.
// Assumes: two-bit command field driven by the issuing sequencer.
package divstep_pkg;

    typedef enum logic [1:0] {
        DS_INIT_UNS = 2'd0,
        DS_INIT_SGN = 2'd1,
        DS_STEP     = 2'd2,
        DS_LOAD_T   = 2'd3
    } ds_op_e;

    typedef struct packed {
        logic q;
        logic m;
        logic t;
    } ds_flags_t;

endpackage

// File: rtl/divstep_addsub.sv
// Module: W-bit adder/subtractor with a carry (or borrow) out of the top.
// Assumes: unsigned operands; on subtract, carry_out=1 means operand > base.
module divstep_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] base,
    input  logic [W-1:0] operand,
    input  logic         do_sub,
    output logic [W-1:0] result,
    output logic         carry_out
);
    localparam int XW = W + 1;

    logic [XW-1:0] ext;

    // Widen by one bit so the carry/borrow lands in the extra position.
    always_comb begin
        if (do_sub) begin
            ext = {1'b0, base} - {1'b0, operand};
        end else begin
            ext = {1'b0, base} + {1'b0, operand};
        end
    end

    assign result    = ext[W-1:0];
    assign carry_out = ext[W];

endmodule

// File: rtl/divstep_init.sv
// Module: computes the state bits for the two set-up commands.
// Assumes: only the sign bits of the operands matter for the flags.
module divstep_init
    import divstep_pkg::*;
(
    input  logic      a_msb,
    input  logic      b_msb,
    input  logic      signed_mode,
    output ds_flags_t flags_init
);
    // Unsigned set-up clears everything; signed set-up takes the operand signs.
    always_comb begin
        if (signed_mode) begin
            flags_init.q = a_msb;
            flags_init.m = b_msb;
            flags_init.t = a_msb ^ b_msb;
        end else begin
            flags_init = '0;
        end
    end

endmodule

// File: rtl/divstep_stepper.sv
// Module: combinational next state for one non-restoring division iteration.
// Assumes: remainder and divisor are W-bit unsigned words, W >= 2.
module divstep_stepper
    import divstep_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] rem_cur,
    input  logic [W-1:0] divisor,
    input  ds_flags_t    flags_cur,
    output logic [W-1:0] rem_next,
    output ds_flags_t    flags_next
);
    localparam int MSB = W - 1;

    logic [W-1:0] shifted;
    logic [W-1:0] sum;
    logic         q_shift;
    logic         do_sub;
    logic         cout;

    assign q_shift = rem_cur[MSB];
    assign shifted = {rem_cur[MSB-1:0], flags_cur.t};
    assign do_sub  = (flags_cur.q == flags_cur.m);

    divstep_addsub #(.W(W)) u_addsub (
        .base      (shifted),
        .operand   (divisor),
        .do_sub    (do_sub),
        .result    (sum),
        .carry_out (cout)
    );

    // Fold the carry into Q and derive the next quotient bit in T.
    always_comb begin
        rem_next     = sum;
        flags_next.m = flags_cur.m;
        flags_next.q = q_shift ^ flags_cur.m ^ cout;
        flags_next.t = (flags_next.q == flags_cur.m);
    end

endmodule

// File: rtl/divstep_unit.sv
// Module: top of the division step unit; holds remainder, divisor and Q/M/T.
// Assumes: one command per cycle at most; results visible the next cycle.
module divstep_unit
    import divstep_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmd_valid,
    input  logic [1:0]   cmd_op,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic         t_in,
    output logic [W-1:0] rem_out,
    output logic         q_out,
    output logic         m_out,
    output logic         t_out,
    output logic         done
);
    logic [W-1:0] rem_q;
    logic [W-1:0] div_q;
    ds_flags_t    flags_q;
    logic         done_q;

    logic [W-1:0] step_rem;
    ds_flags_t    step_flags;
    ds_flags_t    init_flags;
    ds_op_e       op;

    assign op = ds_op_e'(cmd_op);

    divstep_init u_init (
        .a_msb       (opnd_a[W-1]),
        .b_msb       (opnd_b[W-1]),
        .signed_mode (op == DS_INIT_SGN),
        .flags_init  (init_flags)
    );

    divstep_stepper #(.W(W)) u_step (
        .rem_cur    (rem_q),
        .divisor    (div_q),
        .flags_cur  (flags_q),
        .rem_next   (step_rem),
        .flags_next (step_flags)
    );

    // State update: apply the accepted command, flag completion next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q   <= '0;
            div_q   <= '0;
            flags_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= cmd_valid;
            if (cmd_valid) begin
                case (op)
                    DS_INIT_UNS, DS_INIT_SGN: begin
                        rem_q   <= opnd_a;
                        div_q   <= opnd_b;
                        flags_q <= init_flags;
                    end
                    DS_STEP: begin
                        rem_q   <= step_rem;
                        flags_q <= step_flags;
                    end
                    default: begin
                        flags_q.t <= t_in;
                    end
                endcase
            end
        end
    end

    assign rem_out = rem_q;
    assign q_out   = flags_q.q;
    assign m_out   = flags_q.m;
    assign t_out   = flags_q.t;
    assign done    = done_q;

endmodule

// File: rtl/divstep_unit_chk.sv
// Module: assertion checker bound to divstep_unit.
// Assumes: observes ports only; reset is synchronous active-low.
module divstep_unit_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cmd_valid,
    input logic [1:0]   cmd_op,
    input logic [W-1:0] opnd_a,
    input logic         b_msb,
    input logic         t_in,
    input logic [W-1:0] rem_out,
    input logic         q_out,
    input logic         m_out,
    input logic         t_out,
    input logic         done
);
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (rem_out == '0 && !q_out && !m_out && !t_out && !done));

    p_uns_setup_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd0) |=>
            (!q_out && !m_out && !t_out && rem_out == $past(opnd_a)));

    p_sgn_setup_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd1) |=>
            (q_out == $past(opnd_a[W-1]) && m_out == $past(b_msb) &&
             t_out == (q_out ^ m_out)));

    p_step_keeps_m_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd2) |=> $stable(m_out));

    p_step_t_follows_q_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd2) |=> (t_out == (q_out == m_out)));

    p_load_t_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd3) |=>
            (t_out == $past(t_in) && $stable(rem_out) && $stable(q_out) && $stable(m_out)));

    p_done_after_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> done);

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> (!done && $stable(rem_out) && $stable(q_out) &&
                        $stable(m_out) && $stable(t_out)));

endmodule

bind divstep_unit divstep_unit_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .opnd_a    (opnd_a),
    .b_msb     (opnd_b[W-1]),
    .t_in      (t_in),
    .rem_out   (rem_out),
    .q_out     (q_out),
    .m_out     (m_out),
    .t_out     (t_out),
    .done      (done)
);

// File: tb/divstep_unit_tb_top.sv
`timescale 1ns/1ps
module divstep_unit_tb_top;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_valid = 1'b0;
    logic [1:0]   cmd_op = 2'd0;
    logic [W-1:0] opnd_a = '0;
    logic [W-1:0] opnd_b = '0;
    logic         t_in = 1'b0;
    logic [W-1:0] rem_out;
    logic         q_out, m_out, t_out, done;

    int n_checks = 0;
    int n_fails  = 0;
    logic [31:0] lcg = 32'h1234_5678;

    always #2.5 clk = ~clk;

    divstep_unit #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .t_in(t_in),
        .rem_out(rem_out), .q_out(q_out), .m_out(m_out), .t_out(t_out), .done(done)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rnd();
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        return lcg;
    endfunction

    // Arithmetic model of one iteration, taken from R4..R7.
    function automatic void model_step(input logic [31:0] r, input logic [31:0] d,
                                       input logic q, input logic m, input logic t,
                                       output logic [31:0] er, output logic eq, output logic et);
        logic [31:0] sh;
        logic [32:0] s;
        logic c;
        sh = {r[30:0], t};
        if (q == m) begin
            er = sh - d;
            c  = (d > sh);
        end else begin
            s  = {1'b0, sh} + {1'b0, d};
            er = s[31:0];
            c  = s[32];
        end
        eq = r[31] ^ m ^ c;
        et = (eq == m);
    endfunction

    // Issue one command at a falling edge; returns at the next falling edge.
    task automatic do_cmd(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b, input logic tv);
        cmd_valid = 1'b1; cmd_op = op; opnd_a = a; opnd_b = b; t_in = tv;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // Rotate-and-step loop shared by both division sequences.
    task automatic run_loop(inout logic [31:0] lo);
        for (int i = 0; i < 32; i++) begin
            logic nt;
            nt = lo[31];
            lo = {lo[30:0], t_out};
            do_cmd(2'd3, 32'd0, 32'd0, nt);
            do_cmd(2'd2, 32'd0, 32'd0, 1'b0);
        end
        lo = {lo[30:0], t_out};
    endtask

    task automatic div_uns(input logic [31:0] a, input logic [31:0] b);
        logic [31:0] lo;
        lo = a;
        do_cmd(2'd0, 32'd0, b, 1'b0);
        run_loop(lo);
        check(lo == a / b, "R10 unsigned quotient", {32'd0, lo}, {32'd0, a / b});
    endtask

    task automatic div_sgn(input int a, input int b);
        logic [31:0] lo, hi;
        logic        top;
        int          exp_q;
        hi = (a < 0) ? 32'hFFFF_FFFF : 32'd0;
        lo = (a < 0) ? 32'(a - 1) : 32'(a);
        do_cmd(2'd1, hi, 32'(b), 1'b0);
        for (int i = 0; i < 32; i++) begin
            logic nt;
            nt = lo[31];
            lo = {lo[30:0], t_out};
            do_cmd(2'd3, 32'd0, 32'd0, nt);
            do_cmd(2'd2, 32'd0, 32'd0, 1'b0);
        end
        top = lo[31];
        lo  = {lo[30:0], t_out};
        lo  = lo + {31'd0, top};
        exp_q = a / b;
        check(lo == 32'(exp_q), "R11 signed quotient", {32'd0, lo}, {32'd0, 32'(exp_q)});
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin : main
        logic [31:0] ulist_a [12];
        logic [31:0] ulist_b [8];
        logic [31:0] er, ra, rb;
        logic        eq, et, em, mode, tb;

        ulist_a = '{32'd0, 32'd1, 32'd2, 32'd7, 32'd100, 32'd255, 32'd1000, 32'd65535,
                    32'h7FFF_FFFF, 32'h8000_0000, 32'hDEAD_BEEF, 32'hFFFF_FFFF};
        ulist_b = '{32'd1, 32'd2, 32'd3, 32'd7, 32'd10, 32'd255, 32'h0001_0000, 32'h8000_0001};

        repeat (4) @(negedge clk);
        check(rem_out == 0 && !q_out && !m_out && !t_out && !done, "R1 reset state",
              {27'd0, done, q_out, m_out, t_out, 1'b0, rem_out}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(rem_out == 0 && !done, "R1 after release", {31'd0, done, rem_out}, 64'd0);

        // R2: unsigned set-up after flags were set by a signed one.
        do_cmd(2'd1, 32'h8000_0000, 32'd5, 1'b0);
        do_cmd(2'd0, 32'h0000_1234, 32'h55, 1'b0);
        check(rem_out == 32'h1234 && !q_out && !m_out && !t_out, "R2 unsigned set-up",
              {29'd0, q_out, m_out, t_out, rem_out}, {32'd0, 32'h1234});
        check(done == 1'b1, "R9 done after command", {63'd0, done}, 64'd1);
        @(negedge clk);
        check(done == 1'b0 && rem_out == 32'h1234, "R9 idle hold", {31'd0, done, rem_out}, {32'd0, 32'h1234});

        // R3: signed set-up sign combinations.
        do_cmd(2'd1, 32'h8000_0000, 32'd1, 1'b0);
        check(q_out && !m_out && t_out, "R3 neg/pos", {61'd0, q_out, m_out, t_out}, 64'b101);
        do_cmd(2'd1, 32'd0, 32'hFFFF_FFF9, 1'b0);
        check(!q_out && m_out && t_out, "R3 pos/neg", {61'd0, q_out, m_out, t_out}, 64'b011);
        do_cmd(2'd1, 32'hFFFF_0000, 32'hFFFF_FFF9, 1'b0);
        check(q_out && m_out && !t_out && rem_out == 32'hFFFF_0000, "R3 neg/neg",
              {29'd0, q_out, m_out, t_out, rem_out}, {29'd0, 3'b110, 32'hFFFF_0000});

        // R8: load T both ways, other state untouched.
        do_cmd(2'd3, 32'd0, 32'd0, 1'b1);
        check(t_out && q_out && m_out && rem_out == 32'hFFFF_0000, "R8 load T high",
              {29'd0, q_out, m_out, t_out, rem_out}, {29'd0, 3'b111, 32'hFFFF_0000});
        do_cmd(2'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
        check(!t_out && q_out && m_out && rem_out == 32'hFFFF_0000, "R8 load T low",
              {29'd0, q_out, m_out, t_out, rem_out}, {29'd0, 3'b110, 32'hFFFF_0000});

        // R4..R7: single and chained steps from varied starting states.
        for (int k = 0; k < 300; k++) begin
            logic [31:0] cr;
            logic cq, ct;
            ra = rnd(); rb = rnd(); mode = ra[3]; tb = rb[7];
            if (k % 5 == 0) rb = {8'd0, rb[23:0]};
            do_cmd(mode ? 2'd1 : 2'd0, ra, rb, 1'b0);
            do_cmd(2'd3, 32'd0, 32'd0, tb);
            cr = ra;
            cq = mode & ra[31];
            em = mode & rb[31];
            ct = tb;
            for (int s = 0; s < 2; s++) begin
                model_step(cr, rb, cq, em, ct, er, eq, et);
                do_cmd(2'd2, 32'd0, 32'd0, 1'b0);
                check(rem_out == er, (cq == em) ? "R5 subtract remainder" : "R6 add remainder",
                      {32'd0, rem_out}, {32'd0, er});
                check(q_out == eq && t_out == et, "R7 Q and T after step",
                      {62'd0, q_out, t_out}, {62'd0, eq, et});
                check(m_out == em && rem_out[0] == er[0], "R4 M kept",
                      {63'd0, m_out}, {63'd0, em});
                cr = er; cq = eq; ct = et;
            end
        end

        // R10: unsigned full quotients.
        foreach (ulist_a[i]) begin
            foreach (ulist_b[j]) begin
                div_uns(ulist_a[i], ulist_b[j]);
            end
        end
        for (int k = 0; k < 40; k++) begin
            ra = rnd(); rb = rnd() >> (k % 31);
            if (rb == 0) rb = 32'd3;
            div_uns(ra, rb);
        end

        // R11: signed sweep and extremes.
        for (int a = -20; a <= 20; a++) begin
            for (int b = -6; b <= 6; b++) begin
                if (b != 0) div_sgn(a, b);
            end
        end
        div_sgn(2147483647, 7);
        div_sgn(-2147483647, -7);
        div_sgn(-1000003, 13);
        div_sgn(123456789, -1000);
        div_sgn(-2147483647, 2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule